// File: doc/BRIEF.md
# Infrared Carrier Generator for an Output Pin

The block derives an infrared remote-control carrier from the oscillator clock and uses it to modulate one output pin. A two-bit mode input chooses between a disabled carrier and three dividers: divide-by-8 at half duty, divide-by-12 at half duty, and divide-by-12 at one-third duty. With a 455 kHz oscillator the first two give carriers of roughly 56.9 kHz and 37.9 kHz. When a carrier is running, the pin shows the pin's data latch bit ANDed with the carrier. When the carrier is disabled, the pin shows the latch bit as it is.

The mode input is normally wired to the top two bits of the controller's status register. The latch input comes from bit 0 of the output port register, whose reset value is 0. Firmware creates a burst of carrier by writing 1 to the latch bit and a gap by writing 0. Any change of mode restarts the divider at phase 0. In the disabled mode the divider is held at phase 0 and does not toggle.

Top module: `ir_carrier_gen`

## Requirements
- R1: While `rst` is high and on the first clock after it, `pin_drive` is 0 and the divider is at phase 0 with the mode taken as disabled.
- R2: With `carrier_mode` = 2'b00 (no carrier), `pin_drive` equals the value `latch_bit` had one clock earlier.
- R3: With `carrier_mode` = 2'b01, the carrier repeats every 8 clocks and is high for 4 of them and low for 4.
- R4: With `carrier_mode` = 2'b10, the carrier repeats every 12 clocks and is high for 6 of them and low for 6.
- R5: With `carrier_mode` = 2'b11, the carrier repeats every 12 clocks and is high for 4 of them and low for 8.
- R6: With any carrier mode enabled, `pin_drive` is the registered AND of `latch_bit` and the carrier. A latch value of 0 holds the pin low.
- R7: A change of `carrier_mode` restarts the divider at phase 0. The second clock after the change begins a full high phase of the new mode, and the first clock after the change still reflects the old mode.
- R8: While the mode is 2'b00 the divider stays at phase 0, so entering a carrier mode always starts at the beginning of a high phase.
- R9: `pin_drive` comes straight from a flip-flop. A change on `latch_bit` or `carrier_mode` first affects it at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_mode | input | 2 | 00 off, 01 divide-by-8 half duty, 10 divide-by-12 half duty, 11 divide-by-12 third duty |
| latch_bit | input | 1 | Data latch bit of the modulated pin |
| pin_drive | output | 1 | Registered drive level for the pin |

## Verification
The bench builds the block with its default ratios of 8 and 12. With these values all four modes have periods short enough to capture several full periods in every test, and the one-third high time (4 clocks) differs from the half-duty high time (6 clocks) on the same 12-clock period. A behavioural model tracks the phase and mode with integers and is compared with the pin on every clock. This brings mid-period mode changes, long stays in the disabled mode and latch gating within reach at cycle accuracy.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
  typedef enum logic [1:0] {
    CG_OFF    = 2'b00,
    CG_DIV8H  = 2'b01,
    CG_DIV12H = 2'b10,
    CG_DIV12T = 2'b11
  } cg_mode_e;
endpackage

// File: rtl/ircg_mode_reg.sv
module ircg_mode_reg
  import ircg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_in,
  output cg_mode_e   mode_q,
  output logic       restart
);
  cg_mode_e mode_d;
  assign mode_d = cg_mode_e'(mode_in);

  // restart whenever the mode moves, and continuously while off
  assign restart = (mode_d != mode_q) || (mode_d == CG_OFF);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= CG_OFF;
    else     mode_q <= mode_d;
  end

  // R7: a new mode is recorded one edge after it appears
  p_mode_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_d != mode_q) |=> (mode_q == $past(mode_d)));
endmodule

// File: rtl/ircg_decode.sv
module ircg_decode
  import ircg_pkg::*;
#(
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 12,
  parameter int CW       = 4
) (
  input  cg_mode_e         mode_q,
  output logic [CW-1:0]    last_ph,
  output logic [CW-1:0]    hi_len,
  output logic             enable
);
  localparam int FAST_HALF  = FAST_DIV / 2;
  localparam int SLOW_HALF  = SLOW_DIV / 2;
  localparam int SLOW_THIRD = SLOW_DIV / 3;

  always_comb begin
    enable  = 1'b1;
    last_ph = '0;
    hi_len  = '0;
    unique case (mode_q)
      CG_DIV8H: begin
        last_ph = CW'(FAST_DIV - 1);
        hi_len  = CW'(FAST_HALF);
      end
      CG_DIV12H: begin
        last_ph = CW'(SLOW_DIV - 1);
        hi_len  = CW'(SLOW_HALF);
      end
      CG_DIV12T: begin
        last_ph = CW'(SLOW_DIV - 1);
        hi_len  = CW'(SLOW_THIRD);
      end
      default: enable = 1'b0;
    endcase
  end
endmodule

// File: rtl/ircg_phase.sv
module ircg_phase #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] last_ph,
  output logic [CW-1:0] ph
);
  always_ff @(posedge clk) begin
    if (rst || restart)      ph <= '0;
    else if (ph == last_ph)  ph <= '0;
    else                     ph <= ph + 1'b1;
  end

  // R7: restart lands on phase 0
  p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ph == '0));
  // R3: the phase never passes the end of the selected period
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (!restart && ph == last_ph) |=> (ph == '0));
endmodule

// File: rtl/ircg_drive.sv
module ircg_drive #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [CW-1:0] ph,
  input  logic [CW-1:0] hi_len,
  input  logic          latch_bit,
  output logic          pin
);
  logic carrier;
  assign carrier = (ph < hi_len);

  always_ff @(posedge clk) begin
    if (rst)         pin <= 1'b0;
    else if (enable) pin <= latch_bit & carrier;
    else             pin <= latch_bit;
  end

  // R2: pass-through when the carrier is off
  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (pin == $past(latch_bit)));
  // R6: a low latch always gives a low pin
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !latch_bit |=> !pin);
  // R5: the low part of the period never drives high
  p_low_phase_r5: assert property (@(posedge clk) disable iff (rst)
    (enable && ph >= hi_len) |=> !pin);
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ircg_pkg::*;
#(
  parameter int FAST_DIV = 8,
  parameter int SLOW_DIV = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] carrier_mode,
  input  logic       latch_bit,
  output logic       pin_drive
);
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CW      = $clog2(MAX_DIV + 1);

  cg_mode_e      mode_q;
  logic          restart;
  logic [CW-1:0] last_ph;
  logic [CW-1:0] hi_len;
  logic          enable;
  logic [CW-1:0] ph;

  ircg_mode_reg u_mode (
    .clk(clk), .rst(rst), .mode_in(carrier_mode),
    .mode_q(mode_q), .restart(restart)
  );

  ircg_decode #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .CW(CW)) u_dec (
    .mode_q(mode_q), .last_ph(last_ph), .hi_len(hi_len), .enable(enable)
  );

  ircg_phase #(.CW(CW)) u_ph (
    .clk(clk), .rst(rst), .restart(restart), .last_ph(last_ph), .ph(ph)
  );

  ircg_drive #(.CW(CW)) u_drv (
    .clk(clk), .rst(rst), .enable(enable), .ph(ph), .hi_len(hi_len),
    .latch_bit(latch_bit), .pin(pin_drive)
  );

  // R8: divider rests at phase 0 while disabled
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == CG_OFF) |-> (ph == '0));
  // R1: first cycle out of reset is clean
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!pin_drive && ph == '0 && mode_q == CG_OFF));
endmodule

// File: tb/tb_ir_carrier_gen.sv
module tb_ir_carrier_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] carrier_mode = 2'b00;
  logic       latch_bit = 1'b0;
  logic       pin_drive;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  ir_carrier_gen dut (
    .clk(clk), .rst(rst), .carrier_mode(carrier_mode),
    .latch_bit(latch_bit), .pin_drive(pin_drive)
  );

  // behavioural reference: integers for mode and phase
  int   m_mode = 0;
  int   m_ph   = 0;
  logic m_pin  = 1'b0;

  function automatic int per_of(int m);
    return (m == 1) ? 8 : 12;
  endfunction
  function automatic int hi_of(int m);
    if (m == 1) return 4;
    if (m == 2) return 6;
    return 4;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_ph = 0; m_pin = 1'b0;
    end else begin
      if (m_mode == 0) m_pin = latch_bit;
      else             m_pin = latch_bit && (m_ph < hi_of(m_mode));
      if (int'(carrier_mode) != m_mode || carrier_mode == 2'b00) m_ph = 0;
      else m_ph = (m_ph + 1) % per_of(m_mode);
      m_mode = int'(carrier_mode);
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      string tag;
      if (rst)               tag = "R1";
      else if (m_mode == 0)  tag = "R2";
      else if (!m_pin)       tag = "R6";
      else if (m_mode == 1)  tag = "R3";
      else if (m_mode == 2)  tag = "R4";
      else                   tag = "R5";
      check(tag, pin_drive, m_pin);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // capture pin over several periods after a mode change
  task automatic run_mode(string req, logic [1:0] md, int per, int hi);
    logic s [0:40];
    int   cnt;
    @(negedge clk);
    latch_bit    = 1'b1;
    carrier_mode = md;
    for (int k = 1; k <= 2 * per + 2; k++) begin
      @(negedge clk);
      s[k] = pin_drive;
    end
    cnt = 0;
    for (int k = 2; k <= per + 1; k++) if (s[k]) cnt++;
    check_int(req, cnt, hi);                 // high clocks per period
    check({req, "/R7"}, s[2], 1'b1);         // full high phase starts
    check(req, s[hi + 2], 1'b0);             // high ends after hi clocks
    check(req, s[per + 2], 1'b1);            // next period starts high
  endtask

  initial begin
    cmp_en = 1'b1;
    idle(3);
    check("R1", pin_drive, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", pin_drive, 1'b0);

    // R2 / R9: pass-through, one clock later
    latch_bit = 1'b1;
    check("R9", pin_drive, 1'b0);
    @(negedge clk);
    check("R2", pin_drive, 1'b1);
    latch_bit = 1'b0;
    @(negedge clk);
    check("R2", pin_drive, 1'b0);
    latch_bit = 1'b1;
    idle(37);                                // R8: long idle in off mode

    run_mode("R3", 2'b01, 8, 4);
    run_mode("R4", 2'b10, 12, 6);           // direct change from 01
    idle(5);                                 // mid-period
    run_mode("R5", 2'b11, 12, 4);           // R7: restart from mid-period

    // R6: latch low holds pin low while carrier runs
    begin
      int highs = 0;
      carrier_mode = 2'b01;
      latch_bit = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (pin_drive) highs++;
      end
      check_int("R6", highs, 0);
    end

    // R8: return to off, sit, re-enter: begins with high phase
    carrier_mode = 2'b00;
    latch_bit = 1'b1;
    idle(13);
    run_mode("R8", 2'b11, 12, 4);

    carrier_mode = 2'b00;
    latch_bit = 1'b0;
    idle(2);
    check("R2", pin_drive, 1'b0);

    cmp_en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule